// File: doc/BRIEF.md
# Atomic memory operation unit

This unit runs one atomic read-modify-write instruction against a single-port synchronous memory. A request carries the opcode byte, the 32-bit immediate, the base register, a signed 16-bit displacement, the source register and R0. The unit decodes the request and takes the memory lock. It then reads the addressed word, computes the new value, writes it back when the operation calls for that, and releases the lock. It finishes with a one-cycle `done_o` strobe and, when needed, a write-back request for the source register or for R0.

Accesses are 32 or 64 bits wide. A 32-bit operation uses only the low halves of its operands and of memory. It writes only the low word, and it zero-extends every value it returns. An opcode or immediate outside the supported set ends at once with `err_o`. Such a request never takes the lock and never touches memory.

The lock stays asserted from the cycle before the read until the write is finished, so no other requester can reach memory in between. Address translation and arbitration between several masters are left to the surrounding logic.

Top module: `amo_unit`

## Requirements
- R1: Only opcode 0xc3 (32-bit) and 0xdb (64-bit) are accepted. Any other opcode, including the byte form 0xd3 and the halfword form 0xcb, gives `err_o` with `done_o` one cycle after start. It makes no memory request and no register write-back.
- R2: Only immediates 0x00, 0x01, 0x40, 0x41, 0x50, 0x51, 0xa0, 0xa1, 0xe1 and 0xf1 are accepted, with bits 31:8 zero. Any other value, including 0xe0 and 0xf0, is rejected in the same way as in R1.
- R3: Immediate bits 7:1 select add (0x00), or (0x40), and (0x50) or xor (0xa0). Memory receives the old value combined with the source, wrapping at the access width.
- R4: Immediate bit 0 is the fetch flag. On the simple operations, when it is set, `src_we_o` is raised and `src_o` carries the old memory value. When it is clear, `src_we_o` stays low.
- R5: Exchange (0xe1) writes the source value to memory and returns the old value through `src_o`/`src_we_o`.
- R6: Compare-exchange (0xf1) writes the source value only when the old value equals R0 at the access width. In every case it raises `r0_we_o` with the old value and leaves `src_we_o` low.
- R7: The memory address is `base_i` plus `offset_i` sign-extended, and it stays constant while the lock is held.
- R8: For a 32-bit operation, `mem_wide_o` is low and bits 63:32 of the write data are zero. Returned values are zero-extended, and only the low halves of the source, R0 and memory enter the computation.
- R9: A legal request runs: lock (1 cycle), read, compute, write (only if needed), done. `done_o` rises 5 cycles after the accepting edge when a write happens and 4 cycles after when it does not. It is high for one cycle. Every memory request falls inside the lock, and the lock drops as `done_o` rises.
- R10: Operands are captured at the accepting edge. `start_i` and input changes while `busy_o` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, accepted when idle |
| opcode_i | input | 8 | Instruction opcode byte |
| imm_i | input | 32 | Immediate selecting the operation |
| base_i | input | 64 | Base (destination) register value |
| offset_i | input | 16 | Signed address displacement |
| src_i | input | 64 | Source register value |
| r0_i | input | 64 | R0 value, compare operand |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Request rejected, valid with done_o |
| src_we_o | output | 1 | Write src_o back to the source register |
| src_o | output | 64 | Old memory value for the source register |
| r0_we_o | output | 1 | Write r0_o back to R0 |
| r0_o | output | 64 | Old memory value for R0 |
| mem_lock_o | output | 1 | Exclusive memory hold |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_wide_o | output | 1 | 64-bit access; low 32 bits only when 0 |
| mem_addr_o | output | 64 | Byte address |
| mem_wdata_o | output | 64 | Write data |
| mem_rdata_i | input | 64 | Read data, valid the cycle after a read request |

## Verification
The bench goes after the 32-bit wrap cases. There the memory word's upper half must survive a narrow write and the returned value must lose the upper bits. A unit that mixed in the upper halves would corrupt memory or return sign junk. Compare-exchange is driven with R0 equal to memory only in its low half: a 32-bit request must count that as a match and write, and a 64-bit request must count it as a miss and leave memory untouched. Fetch-less and illegal encodings (0xe0, 0xf0, bit 8 set, the byte and halfword sizes) are checked to raise no register write-back and no memory request at all. A second start during a busy sequence, with changed operands, is checked to leave both the result and the following idle cycles unaffected.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [2:0] {
    AMO_ADD, AMO_OR, AMO_AND, AMO_XOR, AMO_XCHG, AMO_CMPX
  } amo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOCK, ST_READ, ST_CALC, ST_WRITE, ST_DONE
  } amo_st_e;

  localparam logic [7:0] OPC_AMO_W  = 8'hc3;
  localparam logic [7:0] OPC_AMO_DW = 8'hdb;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [7:0]       opcode_i,
  input  logic [IMM_W-1:0] imm_i,
  output amo_op_e          op_o,
  output logic             fetch_o,
  output logic             wide_o,
  output logic             err_o
);
  logic bad_opc, bad_imm;

  always_comb begin
    op_o    = AMO_ADD;
    fetch_o = imm_i[0];
    wide_o  = (opcode_i == OPC_AMO_DW);
    bad_opc = !((opcode_i == OPC_AMO_W) || (opcode_i == OPC_AMO_DW));
    bad_imm = |imm_i[IMM_W-1:8];
    unique case (imm_i[7:0])
      8'h00, 8'h01: op_o = AMO_ADD;
      8'h40, 8'h41: op_o = AMO_OR;
      8'h50, 8'h51: op_o = AMO_AND;
      8'ha0, 8'ha1: op_o = AMO_XOR;
      8'he1:        op_o = AMO_XCHG;
      8'hf1:        op_o = AMO_CMPX;
      default:      bad_imm = 1'b1;
    endcase
    err_o = bad_opc | bad_imm;
  end
endmodule

// File: rtl/amo_calc.sv
module amo_calc
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  amo_op_e         op_i,
  input  logic            wide_i,
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] r0_i,
  output logic [XLEN-1:0] new_o,
  output logic            wr_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] mask, a, b, c, raw;

  assign mask = wide_i ? '1 : {{HALF{1'b0}}, {HALF{1'b1}}};
  assign a    = old_i & mask;
  assign b    = src_i & mask;
  assign c    = r0_i & mask;

  always_comb begin
    unique case (op_i)
      AMO_OR:  raw = a | b;
      AMO_AND: raw = a & b;
      AMO_XOR: raw = a ^ b;
      AMO_XCHG, AMO_CMPX: raw = b;
      default: raw = a + b;
    endcase
  end

  assign new_o = raw & mask;
  assign wr_o  = (op_i != AMO_CMPX) || (a == c);
endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic err_i,
  input  logic wr_i,
  output logic accept_o,
  output logic calc_o,
  output logic lock_o,
  output logic req_o,
  output logic we_o,
  output logic done_o,
  output logic busy_o
);
  amo_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = err_i ? ST_DONE : ST_LOCK;
      ST_LOCK:  st_d = ST_READ;
      ST_READ:  st_d = ST_CALC;
      ST_CALC:  st_d = wr_i ? ST_WRITE : ST_DONE;
      ST_WRITE: st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign accept_o = (st_q == ST_IDLE) && start_i;
  assign calc_o   = (st_q == ST_CALC);
  assign lock_o   = (st_q == ST_LOCK) || (st_q == ST_READ) ||
                    (st_q == ST_CALC) || (st_q == ST_WRITE);
  assign req_o    = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign we_o     = (st_q == ST_WRITE);
  assign done_o   = (st_q == ST_DONE);
  assign busy_o   = (st_q != ST_IDLE);
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int OFFS_W = 16,
  parameter int IMM_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [OFFS_W-1:0] offset_i,
  input  logic [XLEN-1:0]   src_i,
  input  logic [XLEN-1:0]   r0_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              src_we_o,
  output logic [XLEN-1:0]   src_o,
  output logic              r0_we_o,
  output logic [XLEN-1:0]   r0_o,
  output logic              mem_lock_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_wide_o,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  input  logic [XLEN-1:0]   mem_rdata_i
);
  localparam int HALF = XLEN / 2;
  localparam int SEXT = XLEN - OFFS_W;

  function automatic logic [XLEN-1:0] fit(input logic [XLEN-1:0] v, input logic w);
    return w ? v : {{HALF{1'b0}}, v[HALF-1:0]};
  endfunction

  amo_op_e         dec_op, op_q;
  logic            dec_fetch, dec_wide, dec_err;
  logic            fetch_q, wide_q, err_q;
  logic [XLEN-1:0] addr_q, src_q, r0_q, old_q, new_q, new_d, old_d;
  logic            wr_d, accept, calc, done;

  amo_decode #(.IMM_W(IMM_W)) u_dec (
    .opcode_i (opcode_i),
    .imm_i    (imm_i),
    .op_o     (dec_op),
    .fetch_o  (dec_fetch),
    .wide_o   (dec_wide),
    .err_o    (dec_err)
  );

  amo_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .err_i    (dec_err),
    .wr_i     (wr_d),
    .accept_o (accept),
    .calc_o   (calc),
    .lock_o   (mem_lock_o),
    .req_o    (mem_req_o),
    .we_o     (mem_we_o),
    .done_o   (done),
    .busy_o   (busy_o)
  );

  assign old_d = fit(mem_rdata_i, wide_q);

  amo_calc #(.XLEN(XLEN)) u_calc (
    .op_i   (op_q),
    .wide_i (wide_q),
    .old_i  (old_d),
    .src_i  (src_q),
    .r0_i   (r0_q),
    .new_o  (new_d),
    .wr_o   (wr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= AMO_ADD;
      fetch_q <= 1'b0;
      wide_q  <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      src_q   <= '0;
      r0_q    <= '0;
      old_q   <= '0;
      new_q   <= '0;
    end else begin
      if (accept) begin
        op_q    <= dec_op;
        fetch_q <= dec_fetch;
        wide_q  <= dec_wide;
        err_q   <= dec_err;
        addr_q  <= base_i + {{SEXT{offset_i[OFFS_W-1]}}, offset_i};
        src_q   <= fit(src_i, dec_wide);
        r0_q    <= fit(r0_i, dec_wide);
      end
      if (calc) begin
        old_q <= old_d;
        new_q <= new_d;
      end
    end
  end

  assign done_o      = done;
  assign err_o       = done && err_q;
  assign src_we_o    = done && !err_q && fetch_q && (op_q != AMO_CMPX);
  assign r0_we_o     = done && !err_q && (op_q == AMO_CMPX);
  assign src_o       = old_q;
  assign r0_o        = old_q;
  assign mem_wide_o  = wide_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = new_q;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            done_o,
  input logic            err_o,
  input logic            src_we_o,
  input logic [XLEN-1:0] src_o,
  input logic            r0_we_o,
  input logic            mem_lock_o,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic            mem_wide_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic [XLEN-1:0] mem_wdata_o
);
  localparam int HALF = XLEN / 2;

  p_req_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_lock_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_release_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_lock_o) |-> done_o);

  p_write_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> $past(mem_lock_o));

  p_addr_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_lock_o && $past(mem_lock_o)) |-> ($stable(mem_addr_o) && $stable(mem_wide_o)));

  p_narrow_wdata_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !mem_wide_o) |-> ((mem_wdata_o >> HALF) == '0));

  p_narrow_ret_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_we_o && !mem_wide_o) |-> ((src_o >> HALF) == '0));

  p_err_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && !src_we_o && !r0_we_o && !mem_lock_o));

  p_one_writeback_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(src_we_o && r0_we_o));
endmodule

bind amo_unit amo_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/amo_unit_test.sv
module amo_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [31:0] imm = '0;
  logic [63:0] base = '0;
  logic [15:0] offset = '0;
  logic [63:0] src = '0;
  logic [63:0] r0 = '0;
  logic        busy_o, done_o, err_o, src_we_o, r0_we_o;
  logic [63:0] src_o, r0_o;
  logic        mem_lock_o, mem_req_o, mem_we_o, mem_wide_o;
  logic [63:0] mem_addr_o, mem_wdata_o;
  logic [63:0] rdata = '0;

  logic [63:0] mem [16];
  logic        pre_we = 1'b0;
  logic [3:0]  pre_idx = '0;
  logic [63:0] pre_val = '0;
  int          req_cnt = 0;
  logic [63:0] last_addr = '0;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  localparam logic [63:0] AREA = 64'h0000_0100_2000_0000;

  always #4 clk = ~clk;

  amo_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode), .imm_i(imm),
    .base_i(base), .offset_i(offset), .src_i(src), .r0_i(r0),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .src_we_o(src_we_o), .src_o(src_o), .r0_we_o(r0_we_o), .r0_o(r0_o),
    .mem_lock_o(mem_lock_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_wide_o(mem_wide_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (pre_we) mem[pre_idx] <= pre_val;
    else if (mem_req_o) begin
      if (mem_we_o) begin
        if (mem_wide_o) mem[mem_addr_o[6:3]] <= mem_wdata_o;
        else            mem[mem_addr_o[6:3]][31:0] <= mem_wdata_o[31:0];
      end else rdata <= mem[mem_addr_o[6:3]];
    end
    if (mem_req_o) begin
      req_cnt   <= req_cnt + 1;
      last_addr <= mem_addr_o;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic void model(input logic [7:0] opc, input logic [31:0] im,
                                input logic [63:0] old, input logic [63:0] s, input logic [63:0] z,
                                output bit err, output int lat, output logic [63:0] mem_new,
                                output bit swe, output bit rwe, output logic [63:0] ret);
    logic [63:0] m, o, sv, zv, n;
    bit wide, legal, wr;
    wide  = (opc == 8'hdb);
    legal = (opc == 8'hc3 || opc == 8'hdb) && (im[31:8] == 0);
    case (im[7:0])
      8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51, 8'ha0, 8'ha1, 8'he1, 8'hf1: ;
      default: legal = 0;
    endcase
    m  = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    o  = old & m; sv = s & m; zv = z & m;
    wr = 1;
    case (im[7:1])
      7'h20:   n = o | sv;
      7'h28:   n = o & sv;
      7'h50:   n = o ^ sv;
      7'h70:   n = sv;
      7'h78: begin n = sv; wr = (o == zv); end
      default: n = o + sv;
    endcase
    n   = n & m;
    err = !legal;
    ret = o;
    if (err) begin
      lat = 1; mem_new = old; swe = 0; rwe = 0;
    end else begin
      lat     = wr ? 5 : 4;
      mem_new = !wr ? old : (wide ? n : {old[63:32], n[31:0]});
      rwe     = (im[7:0] == 8'hf1);
      swe     = im[0] && !rwe;
    end
  endfunction

  task automatic run_op(input logic [7:0] opc, input logic [31:0] im, input int k,
                        input logic [63:0] old, input logic [63:0] s, input logic [63:0] z,
                        input bit glitch, input string tag);
    bit e, swe, rwe;
    int lat, cyc, d, rc;
    logic [63:0] mn, ret, exp_addr;
    model(opc, im, old, s, z, e, lat, mn, swe, rwe, ret);
    @(negedge clk);
    pre_we = 1; pre_idx = 4'(k); pre_val = old;
    @(negedge clk);
    pre_we = 0;
    d = int'($urandom_range(4000)) - 2000;
    exp_addr = AREA + 64'(k * 8);
    base   = exp_addr + 64'(signed'(d));
    offset = 16'(-d);
    opcode = opc; imm = im; src = s; r0 = z;
    rc = req_cnt;
    start = 1;
    @(negedge clk);
    start = 0;
    cyc = 1;
    while (!done_o && cyc < 20) begin
      if (glitch && cyc == 1) begin
        start = 1; imm = im ^ 32'h40; src = ~s; r0 = ~z; offset = offset + 16'h8;
      end else start = 0;
      @(negedge clk);
      cyc++;
    end
    start = 0;
    chk(cyc == lat, {tag, " R9 latency"}, 64'(cyc), 64'(lat));
    chk(err_o == e, {tag, " R1 R2 err"}, 64'(err_o), 64'(e));
    chk(src_we_o == swe, {tag, " R4 src_we"}, 64'(src_we_o), 64'(swe));
    chk(r0_we_o == rwe, {tag, " R6 r0_we"}, 64'(r0_we_o), 64'(rwe));
    if (swe) chk(src_o == ret, {tag, " R4 R5 R8 src"}, src_o, ret);
    if (rwe) chk(r0_o == ret, {tag, " R6 R8 r0"}, r0_o, ret);
    chk(mem[k] == mn, {tag, " R3 memory"}, mem[k], mn);
    if (e) chk(req_cnt == rc, {tag, " R1 no request"}, 64'(req_cnt - rc), 64'd0);
    else   chk(last_addr == exp_addr, {tag, " R7 address"}, last_addr, exp_addr);
    if (glitch) begin
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(!done_o && !busy_o, {tag, " R10 no second run"}, 64'(done_o), 64'd0);
      end
    end else @(negedge clk);
  endtask

  function automatic logic [31:0] legal_imm(input int i);
    case (i)
      0: return 32'h00; 1: return 32'h01; 2: return 32'h40; 3: return 32'h41;
      4: return 32'h50; 5: return 32'h51; 6: return 32'ha0; 7: return 32'ha1;
      8: return 32'he1; default: return 32'hf1;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) mem[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    chk(!done_o && !mem_lock_o && !mem_req_o && !busy_o, "R9 reset idle", 64'(done_o), 64'd0);
    rst_n = 1;
    @(negedge clk);

    run_op(8'hdb, 32'h01, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 0, "add64 wrap");
    run_op(8'hc3, 32'h01, 2, 64'hAAAA_AAAA_FFFF_FFFF, 64'h1234_5678_0000_0002, 64'h0, 0, "add32 wrap R8");
    run_op(8'hdb, 32'h40, 3, 64'h0F0F, 64'hF000_0000_0000_00F0, 64'h0, 0, "or nofetch");
    run_op(8'hc3, 32'h51, 4, 64'h5555_5555_8000_00FF, 64'hFFFF_FFFF_F000_000F, 64'h0, 0, "and32 fetch");
    run_op(8'hdb, 32'ha1, 5, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_0000_FFFF_0000, 64'h0, 0, "xor64 fetch");
    run_op(8'hc3, 32'he1, 6, 64'h7777_7777_8765_4321, 64'h9999_9999_CAFE_BABE, 64'h0, 0, "xchg32 R5");
    run_op(8'hdb, 32'hf1, 7, 64'hDEAD_BEEF_0000_0001, 64'h42, 64'hDEAD_BEEF_0000_0001, 0, "cmpx64 match");
    run_op(8'hdb, 32'hf1, 8, 64'hDEAD_BEEF_0000_0001, 64'h42, 64'h0000_0000_0000_0001, 0, "cmpx64 miss");
    run_op(8'hc3, 32'hf1, 9, 64'hDEAD_BEEF_8000_0001, 64'h42, 64'h1111_1111_8000_0001, 0, "cmpx32 low match");
    run_op(8'hdb, 32'he0, 10, 64'h1, 64'h2, 64'h3, 0, "imm e0 R2");
    run_op(8'hdb, 32'hf0, 10, 64'h1, 64'h2, 64'h3, 0, "imm f0 R2");
    run_op(8'hdb, 32'h02, 10, 64'h1, 64'h2, 64'h3, 0, "imm 02 R2");
    run_op(8'hc3, 32'h100, 10, 64'h1, 64'h2, 64'h3, 0, "imm bit8 R2");
    run_op(8'hcb, 32'h00, 11, 64'h1, 64'h2, 64'h3, 0, "size half R1");
    run_op(8'hd3, 32'h01, 11, 64'h1, 64'h2, 64'h3, 0, "size byte R1");
    run_op(8'h63, 32'h00, 11, 64'h1, 64'h2, 64'h3, 0, "plain store R1");
    run_op(8'hdb, 32'h01, 12, 64'h10, 64'h5, 64'h0, 1, "restart R10");

    for (int n = 0; n < 160; n++) begin
      logic [7:0]  oc;
      logic [31:0] im;
      logic [63:0] ov, sv, zv;
      oc = $urandom_range(1) ? 8'hdb : 8'hc3;
      im = legal_imm(int'($urandom_range(9)));
      if ($urandom_range(11) == 0) im = $urandom & 32'h1FF;
      if ($urandom_range(15) == 0) oc = 8'(32'hc3 | ($urandom_range(3) << 3));
      ov = {$urandom, $urandom};
      sv = {$urandom, $urandom};
      zv = $urandom_range(1) ? ov : {$urandom, $urandom};
      if ($urandom_range(3) == 0) zv = {~ov[63:32], ov[31:0]};
      run_op(oc, im, int'($urandom_range(15)), ov, sv, zv, $urandom_range(7) == 0, "random");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule